// File: doc/BRIEF.md
# Burst Coalescing Memory Port Adapter

This block connects a group of streaming cores to a shared memory-access interconnect that only moves fixed 128-byte bursts. Each core owns one or more local ports: write ports that push 64-bit beats toward memory, and read ports that pull 64-bit beats from it. A single storage array holds a private share for every port. The same storage packs core data into full bursts and absorbs the delay between a read request and the return of its data.

A port becomes eligible for the upstream request channel in one of two ways. A write port is eligible once a whole burst is buffered for it. A read port is eligible once it asks for data and a whole burst of free space can be reserved in its share. A round-robin selector picks among the eligible ports and presents one request at a time, tagged with the port's index. A write request is followed by its 16 data beats. Read data comes back tagged with the same index and goes into that port's share. The core then drains it at its own pace.

Top module: `burst_coalesce_port`

## Requirements
- R1: Every accepted write request (up_req_write=1) is followed by exactly BEATS (16 for 128 bytes over 64 bits) up_wvalid beats. No new request is presented before the last of those beats.
- R2: A write port requests only when at least 16 beats are buffered for it. With 15 beats buffered, no request appears.
- R3: A read port with rd_want high requests only when 16 beats of its share are neither held nor reserved. With a 32-beat share, two outstanding bursts block a third.
- R4: After reset, port 0 has first priority. After each accepted request, priority moves to the port following the granted one, cyclically. Ports that are not eligible are skipped.
- R5: up_req_port is the global port index. Write ports are 0..NUM_WR-1 and read ports are NUM_WR..NUM_WR+NUM_RD-1. up_req_write is 1 exactly for write ports.
- R6: A return beat with up_rport=p is stored in read port p's share only. It is delivered on that port in arrival order, and other read ports stay empty.
- R7: The upstream write beats of a burst are the port's core beats, unchanged and in push order.
- R8: wr_ready of a write port is low while its share holds SHARE_BURSTS×16 beats and high again after a burst drains.
- R9: rd_valid of a read port is low while its share is empty.
- R10: While up_req_valid is high and up_req_ready low, up_req_valid, up_req_port and up_req_write hold.
- R11: After reset, no request or write beat is presented, every wr_ready is high and every rd_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | NUM_WR | Core write beat valid, one bit per write port |
| wr_data | input | NUM_WR*DATA_W | Core write beats, port k at bits k*DATA_W |
| wr_ready | output | NUM_WR | Write share has room |
| rd_want | input | NUM_RD | Core wants more read bursts |
| rd_valid | output | NUM_RD | Read share holds a beat |
| rd_data | output | NUM_RD*DATA_W | Oldest beat of each read share |
| rd_ready | input | NUM_RD | Core takes the offered beat |
| up_req_valid | output | 1 | Burst request present |
| up_req_ready | input | 1 | Interconnect accepts the request |
| up_req_write | output | 1 | 1 for a write burst, 0 for a read burst |
| up_req_port | output | PID_W | Global index of the requesting port |
| up_wvalid | output | 1 | Write burst beat valid |
| up_wdata | output | DATA_W | Write burst beat |
| up_wready | input | 1 | Interconnect takes the write beat |
| up_rvalid | input | 1 | Read return beat valid (always accepted) |
| up_rport | input | PID_W | Port index the return beat belongs to |
| up_rdata | input | DATA_W | Read return beat |

## Verification
The bound checker watches the request channel on every cycle. It confirms that requests hold while stalled, and that a write request is made only when its share holds a full burst. It confirms that a read request is made only when a full burst of space is unreserved, and that each write burst has exactly its beat count with no request overlapping it. It also confirms that no share exceeds its capacity. The fairness order across mixed read and write ports, the data integrity of bursts in both directions, the steering of return beats to the right port, and the flow-control edges at 15, 16 and 32 beats depend on sequences of traffic. Only the bench's scenarios show those.

// File: rtl/bcp_pkg.sv
package bcp_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_DATA = 2'd2
   } bcp_state_e;

   function automatic int unsigned bcp_bits(input int unsigned n);
      int unsigned b;
      b = 1;
      while ((1 << b) < n) b++;
      return b;
   endfunction

   function automatic bit bcp_is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/bcp_rr_arb.sv
module bcp_rr_arb #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          adv,
   input  logic [IW-1:0] adv_idx,
   output logic          gnt_any,
   output logic [IW-1:0] gnt_idx
);

   logic [IW-1:0] last_q;

   function automatic logic [IW-1:0] step(input logic [IW-1:0] base, input int unsigned k);
      int unsigned s;
      s = int'(base) + k;
      if (s >= N) s = s - N;
      return IW'(s);
   endfunction

   always_comb begin
      gnt_any = 1'b0;
      gnt_idx = '0;
      for (int unsigned k = 1; k <= N; k++) begin
         if (!gnt_any && req[step(last_q, k)]) begin
            gnt_any = 1'b1;
            gnt_idx = step(last_q, k);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) last_q <= IW'(N - 1);
      else if (adv) last_q <= adv_idx;
   end

endmodule

// File: rtl/bcp_share_ctl.sv
module bcp_share_ctl #(
   parameter int SHARE = 32,
   parameter int BEATS = 16,
   parameter int OFF_W = 5,
   parameter int CNT_W = 6,
   parameter bit IS_RD = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic             resv,
   output logic [OFF_W-1:0] woff,
   output logic [OFF_W-1:0] roff,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] commit
);

   logic [CNT_W-1:0] commit_inc;

   generate
      if (IS_RD) begin : g_rd
         assign commit_inc = resv ? CNT_W'(BEATS) : '0;
      end else begin : g_wr
         wire unused_resv = resv;
         assign commit_inc = CNT_W'(push);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         woff   <= '0;
         roff   <= '0;
         count  <= '0;
         commit <= '0;
      end else begin
         if (push) woff <= woff + OFF_W'(1);
         if (pop)  roff <= roff + OFF_W'(1);
         count  <= count + CNT_W'(push) - CNT_W'(pop);
         commit <= commit + commit_inc - CNT_W'(pop);
      end
   end

endmodule

// File: rtl/bcp_store.sv
module bcp_store #(
   parameter int NPORT  = 4,
   parameter int SHARE  = 32,
   parameter int DATA_W = 64,
   parameter int OFF_W  = 5,
   parameter int PW     = 2
) (
   input  logic                              clk,
   input  logic [NPORT-1:0]                  we,
   input  logic [NPORT-1:0][OFF_W-1:0]       woff,
   input  logic [NPORT-1:0][DATA_W-1:0]      wdata,
   input  logic [NPORT-1:0][OFF_W-1:0]       roff,
   output logic [NPORT-1:0][DATA_W-1:0]      rdata
);

   localparam int DEPTH = (1 << PW) * SHARE;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      for (int p = 0; p < NPORT; p++) begin
         if (we[p]) mem[{PW'(p), woff[p]}] <= wdata[p];
      end
   end

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_rd
         assign rdata[p] = mem[{PW'(p), roff[p]}];
      end
   endgenerate

endmodule

// File: rtl/burst_coalesce_port.sv
module burst_coalesce_port
   import bcp_pkg::*;
#(
   parameter int NUM_WR       = 2,
   parameter int NUM_RD       = 2,
   parameter int DATA_W       = 64,
   parameter int BURST_BYTES  = 128,
   parameter int SHARE_BURSTS = 2,
   localparam int NPORT = NUM_WR + NUM_RD,
   localparam int PID_W = int'(bcp_bits(NPORT))
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_WR-1:0]        wr_valid,
   input  logic [NUM_WR*DATA_W-1:0] wr_data,
   output logic [NUM_WR-1:0]        wr_ready,
   input  logic [NUM_RD-1:0]        rd_want,
   output logic [NUM_RD-1:0]        rd_valid,
   output logic [NUM_RD*DATA_W-1:0] rd_data,
   input  logic [NUM_RD-1:0]        rd_ready,
   output logic                     up_req_valid,
   input  logic                     up_req_ready,
   output logic                     up_req_write,
   output logic [PID_W-1:0]         up_req_port,
   output logic                     up_wvalid,
   output logic [DATA_W-1:0]        up_wdata,
   input  logic                     up_wready,
   input  logic                     up_rvalid,
   input  logic [PID_W-1:0]         up_rport,
   input  logic [DATA_W-1:0]        up_rdata
);

   localparam int BEATS  = (BURST_BYTES * 8) / DATA_W;
   localparam int SHARE  = BEATS * SHARE_BURSTS;
   localparam int OFF_W  = int'(bcp_bits(SHARE));
   localparam int CNT_W  = int'(bcp_bits(SHARE + 1));
   localparam int BEAT_W = int'(bcp_bits(BEATS));

   generate
      if (DATA_W % 8 != 0)
         $error("DATA_W must be a whole number of bytes");
      if ((BURST_BYTES * 8) % DATA_W != 0)
         $error("burst size must be a whole number of beats");
      if (BEATS < 2 || !bcp_is_pow2(BEATS))
         $error("beats per burst must be a power of two, at least 2");
      if (SHARE_BURSTS < 1 || !bcp_is_pow2(SHARE_BURSTS))
         $error("SHARE_BURSTS must be a power of two, at least 1");
      if (NUM_WR < 1 || NUM_RD < 1)
         $error("at least one write and one read port are required");
   endgenerate

   bcp_state_e state_q;
   logic [PID_W-1:0]  req_port_q;
   logic [BEAT_W-1:0] beat_q;

   logic [NPORT-1:0] push, pop, resv, elig, arb_req;
   logic [NPORT-1:0][CNT_W-1:0]  share_cnt, share_commit;
   logic [NPORT-1:0][OFF_W-1:0]  woff, roff;
   logic [NPORT-1:0][DATA_W-1:0] wdat, rdat;
   logic             gnt_any;
   logic [PID_W-1:0] gnt_idx;
   logic             req_acc;

   assign up_req_valid = (state_q == ST_REQ);
   assign up_req_port  = req_port_q;
   assign up_req_write = int'(req_port_q) < NUM_WR;
   assign up_wvalid    = (state_q == ST_DATA);
   assign up_wdata     = rdat[req_port_q];
   assign req_acc      = up_req_valid & up_req_ready;

   generate
      for (genvar p = 0; p < NUM_WR; p++) begin : g_wport
         assign push[p]     = wr_valid[p] & wr_ready[p];
         assign wdat[p]     = wr_data[p*DATA_W +: DATA_W];
         assign pop[p]      = up_wvalid & up_wready & (req_port_q == PID_W'(p));
         assign resv[p]     = 1'b0;
         assign wr_ready[p] = share_cnt[p] < CNT_W'(SHARE);
         assign elig[p]     = share_cnt[p] >= CNT_W'(BEATS);
      end

      for (genvar j = 0; j < NUM_RD; j++) begin : g_rport
         localparam int P = NUM_WR + j;
         assign push[P]     = up_rvalid & (up_rport == PID_W'(P));
         assign wdat[P]     = up_rdata;
         assign pop[P]      = rd_valid[j] & rd_ready[j];
         assign resv[P]     = req_acc & (req_port_q == PID_W'(P));
         assign rd_valid[j] = share_cnt[P] != '0;
         assign rd_data[j*DATA_W +: DATA_W] = rdat[P];
         assign elig[P]     = rd_want[j] &
                              ((CNT_W'(SHARE) - share_commit[P]) >= CNT_W'(BEATS));
      end

      for (genvar p = 0; p < NPORT; p++) begin : g_ctl
         bcp_share_ctl #(
            .SHARE (SHARE),
            .BEATS (BEATS),
            .OFF_W (OFF_W),
            .CNT_W (CNT_W),
            .IS_RD (p >= NUM_WR)
         ) u_ctl (
            .clk    (clk),
            .rst_n  (rst_n),
            .push   (push[p]),
            .pop    (pop[p]),
            .resv   (resv[p]),
            .woff   (woff[p]),
            .roff   (roff[p]),
            .count  (share_cnt[p]),
            .commit (share_commit[p])
         );
      end
   endgenerate

   bcp_store #(
      .NPORT  (NPORT),
      .SHARE  (SHARE),
      .DATA_W (DATA_W),
      .OFF_W  (OFF_W),
      .PW     (PID_W)
   ) u_store (
      .clk   (clk),
      .we    (push),
      .woff  (woff),
      .wdata (wdat),
      .roff  (roff),
      .rdata (rdat)
   );

   assign arb_req = (state_q == ST_IDLE) ? elig : '0;

   bcp_rr_arb #(
      .N  (NPORT),
      .IW (PID_W)
   ) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (arb_req),
      .adv     (req_acc),
      .adv_idx (req_port_q),
      .gnt_any (gnt_any),
      .gnt_idx (gnt_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         req_port_q <= '0;
         beat_q     <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (gnt_any) begin
               req_port_q <= gnt_idx;
               state_q    <= ST_REQ;
            end
            ST_REQ: if (up_req_ready) begin
               beat_q  <= '0;
               state_q <= up_req_write ? ST_DATA : ST_IDLE;
            end
            ST_DATA: if (up_wready) begin
               beat_q <= beat_q + BEAT_W'(1);
               if (beat_q == BEAT_W'(BEATS - 1)) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bcp_chk.sv
module bcp_chk #(
   parameter int NPORT  = 4,
   parameter int PID_W  = 2,
   parameter int CNT_W  = 6,
   parameter int BEATS  = 16,
   parameter int SHARE  = 32
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        up_req_valid,
   input logic                        up_req_ready,
   input logic                        up_req_write,
   input logic [PID_W-1:0]            up_req_port,
   input logic                        up_wvalid,
   input logic                        up_wready,
   input logic [NPORT-1:0][CNT_W-1:0] share_cnt,
   input logic [NPORT-1:0][CNT_W-1:0] share_commit
);

   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) left_q <= '0;
      else if (up_req_valid && up_req_ready && up_req_write) left_q <= CNT_W'(BEATS);
      else if (up_wvalid && up_wready) left_q <= left_q - CNT_W'(1);
   end

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      up_req_valid && !up_req_ready |=>
         up_req_valid && $stable(up_req_port) && $stable(up_req_write));

   assert_write_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      up_req_valid && up_req_write |-> share_cnt[up_req_port] >= CNT_W'(BEATS));

   assert_read_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
      up_req_valid && !up_req_write |->
         (CNT_W'(SHARE) - share_commit[up_req_port]) >= CNT_W'(BEATS));

   assert_beat_in_burst_R1: assert property (@(posedge clk) disable iff (!rst_n)
      up_wvalid |-> left_q != '0);

   assert_no_req_midburst_R1: assert property (@(posedge clk) disable iff (!rst_n)
      up_req_valid |-> left_q == '0);

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_cap
         assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
            share_cnt[p] <= CNT_W'(SHARE));
      end
   endgenerate

endmodule

bind burst_coalesce_port bcp_chk #(
   .NPORT (NPORT),
   .PID_W (PID_W),
   .CNT_W (CNT_W),
   .BEATS (BEATS),
   .SHARE (SHARE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .up_req_valid (up_req_valid),
   .up_req_ready (up_req_ready),
   .up_req_write (up_req_write),
   .up_req_port  (up_req_port),
   .up_wvalid    (up_wvalid),
   .up_wready    (up_wready),
   .share_cnt    (share_cnt),
   .share_commit (share_commit)
);

// File: tb/burst_coalesce_port_tb.sv
module burst_coalesce_port_tb;

   localparam int NUM_WR = 2;
   localparam int NUM_RD = 2;
   localparam int DW     = 64;
   localparam int BEATS  = 16;

   // vector: [31:26] beats port0, [25:20] beats port1, [19:18] rd_want,
   //         [17:15] grants expected, [11:0] expected ports (2 bits each, first at LSB)
   localparam logic [31:0] VEC [4] = '{
      {6'd16, 6'd16, 2'b00, 3'd2, 3'd0, 12'h004},
      {6'd16, 6'd0,  2'b01, 3'd3, 3'd0, 12'h028},
      {6'd0,  6'd16, 2'b10, 3'd3, 3'd0, 12'h03D},
      {6'd16, 6'd16, 2'b11, 3'd6, 3'd0, 12'hEE4}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NUM_WR-1:0]    wr_valid = '0;
   logic [NUM_WR*DW-1:0] wr_data  = '0;
   logic [NUM_WR-1:0]    wr_ready;
   logic [NUM_RD-1:0]    rd_want  = '0;
   logic [NUM_RD-1:0]    rd_valid;
   logic [NUM_RD*DW-1:0] rd_data;
   logic [NUM_RD-1:0]    rd_ready = '0;
   logic       up_req_valid;
   logic       up_req_ready = 1'b0;
   logic       up_req_write;
   logic [1:0] up_req_port;
   logic       up_wvalid;
   logic [DW-1:0] up_wdata;
   logic       up_wready = 1'b1;
   logic       up_rvalid = 1'b0;
   logic [1:0] up_rport  = '0;
   logic [DW-1:0] up_rdata = '0;

   int n_vec = 0;
   int n_bad = 0;
   int wseq [NUM_WR];
   int wexp [NUM_WR];
   int rseq [NUM_RD];
   int rexp [NUM_RD];
   int outst [NUM_RD];

   always #2 clk = ~clk;

   burst_coalesce_port u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
      .rd_want(rd_want), .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
      .up_req_valid(up_req_valid), .up_req_ready(up_req_ready),
      .up_req_write(up_req_write), .up_req_port(up_req_port),
      .up_wvalid(up_wvalid), .up_wdata(up_wdata), .up_wready(up_wready),
      .up_rvalid(up_rvalid), .up_rport(up_rport), .up_rdata(up_rdata)
   );

   function automatic logic [63:0] wpat(input int p, input int s);
      return {16'hC0DE, 16'(p), 32'(s)};
   endfunction

   function automatic logic [63:0] rpat(input int p, input int s);
      return {16'hBEEF, 16'(p), 32'(s)};
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic push_pair(input int n0, input int n1);
      int n;
      n = (n0 > n1) ? n0 : n1;
      for (int c = 0; c < n; c++) begin
         wr_valid[0] = (c < n0);
         wr_valid[1] = (c < n1);
         wr_data[63:0]   = wpat(0, wseq[0]);
         wr_data[127:64] = wpat(1, wseq[1]);
         if (c < n0) wseq[0]++;
         if (c < n1) wseq[1]++;
         @(negedge clk);
      end
      wr_valid = '0;
   endtask

   task automatic serve(input int ep);
      int t;
      t = 0;
      while (!up_req_valid && t < 300) begin
         @(negedge clk);
         t++;
      end
      chk("R4 grant order", {63'd0, up_req_valid} << 8 | 64'(up_req_port), 64'h100 | 64'(ep));
      chk("R5 direction flag", 64'(up_req_write), 64'(ep < NUM_WR));
      @(negedge clk);
      @(negedge clk);
      chk("R10 request held", {62'd0, up_req_valid, 1'b0} << 4 | 64'(up_req_port), 64'h20 | 64'(ep));
      up_req_ready = 1'b1;
      @(negedge clk);
      up_req_ready = 1'b0;
      if (ep < NUM_WR) begin
         for (int k = 0; k < BEATS; k++) begin
            chk("R7 write beat", up_wvalid ? up_wdata : 64'hDEAD, wpat(ep, wexp[ep]));
            wexp[ep]++;
            @(negedge clk);
         end
         chk("R1 burst ends after 16 beats", 64'(up_wvalid), 64'd0);
      end else begin
         outst[ep - NUM_WR]++;
      end
   endtask

   task automatic return_drain(input int j);
      int p;
      int n;
      p = NUM_WR + j;
      n = outst[j] * BEATS;
      for (int k = 0; k < n; k++) begin
         up_rvalid = 1'b1;
         up_rport  = 2'(p);
         up_rdata  = rpat(p, rseq[j]);
         rseq[j]++;
         @(negedge clk);
      end
      up_rvalid = 1'b0;
      chk("R6 other read port untouched", 64'(rd_valid[1-j]), 64'd0);
      rd_ready[j] = 1'b1;
      for (int k = 0; k < n; k++) begin
         chk("R6 steered read beat", rd_valid[j] ? rd_data[j*DW +: DW] : 64'hDEAD,
             rpat(p, rexp[j]));
         rexp[j]++;
         @(negedge clk);
      end
      rd_ready[j] = 1'b0;
      chk("R9 rd_valid low when empty", 64'(rd_valid[j]), 64'd0);
      outst[j] = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NUM_WR; i++) begin wseq[i] = 0; wexp[i] = 0; end
      for (int i = 0; i < NUM_RD; i++) begin rseq[i] = 0; rexp[i] = 0; outst[i] = 0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state (R11, R9)
      chk("R11 no request after reset", 64'(up_req_valid), 64'd0);
      chk("R11 no write beat after reset", 64'(up_wvalid), 64'd0);
      chk("R11 wr_ready high after reset", 64'(wr_ready), 64'h3);
      chk("R9 rd_valid low after reset", 64'(rd_valid), 64'd0);

      // table of traffic patterns (R1 R3 R4 R5 R6 R7 R9 R10)
      for (int v = 0; v < 4; v++) begin
         push_pair(int'(VEC[v][31:26]), int'(VEC[v][25:20]));
         repeat (2) @(negedge clk);
         rd_want = VEC[v][19:18];
         for (int g = 0; g < int'(VEC[v][17:15]); g++)
            serve(int'(VEC[v][2*g +: 2]));
         repeat (20) @(negedge clk);
         chk("R3 no third read burst", 64'(up_req_valid), 64'd0);
         rd_want = '0;
         for (int j = 0; j < NUM_RD; j++)
            if (outst[j] != 0) return_drain(j);
      end

      // R2: 15 beats are not enough, the 16th triggers a request
      push_pair(15, 0);
      repeat (20) @(negedge clk);
      chk("R2 no request with 15 beats", 64'(up_req_valid), 64'd0);
      push_pair(1, 0);
      serve(0);

      // R8: fill port 1 while the request is stalled
      begin
         int acc;
         acc = 0;
         for (int c = 0; c < 40; c++) begin
            if (wr_ready[1]) begin
               wr_valid[1] = 1'b1;
               wr_data[127:64] = wpat(1, wseq[1]);
               wseq[1]++;
               acc++;
            end else begin
               wr_valid[1] = 1'b0;
            end
            @(negedge clk);
         end
         wr_valid[1] = 1'b0;
         chk("R8 beats accepted until full", 64'(acc), 64'd32);
         chk("R8 wr_ready low when full", 64'(wr_ready[1]), 64'd0);
         serve(1);
         chk("R8 wr_ready back after drain", 64'(wr_ready[1]), 64'd1);
         serve(1);
      end

      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule